// File: doc/BRIEF.md
# Multi-Mode Performance Event Counter

This block is a single counter for a processor performance-monitoring unit. Every clock it looks at a vector of raw sub-event signals from the event detectors and at a small per-cycle event tally. A qualifier mask picks which sub-event bits matter. When any enabled bit is high, the qualified condition is true. Depending on the programmed mode, the counter adds one in these cycles:

- every cycle the condition holds (or, with inversion, every cycle it does not hold);
- every cycle the condition changes value;
- every cycle the tally reaches a programmed threshold.

Software drives a small write port to set the control fields, load the counter and set a reload value. It reads the running count on a dedicated output. For sampling, software loads the counter and the reload register with the negative of the sampling period. When the counter wraps past its all-ones value, three things happen in the same clock:

- it reloads from the reload register;
- no event is lost;
- a sticky interrupt request goes high.

The request stays high until software clears it.

Top module: `perf_event_counter`

## Requirements
- R1: After a synchronous active-low reset, the count output and the interrupt request are 0. The control register is 0 (counter disabled, mask empty, mode 0, threshold 0), the reload value is 0 and the stored previous condition is 0.
- R2: A write with `wr_en` high takes effect at the next rising edge. Address 0 writes the control register. Address 1 loads the counter with `wr_data`. Address 2 sets the reload value. Address 3 changes nothing. Control bits are: bit 0 enable, bits 2:1 mode, bit 3 invert, bit 4 interrupt clear (a write-only action), bits [5 +: EVT_W] qualifier mask, bits [5+EVT_W +: LVL_W] threshold.
- R3: The qualified condition is true when at least one bit of `evt_raw` AND the mask is 1. When the invert bit is 1, the condition is complemented.
- R4: In mode 0 (level), the count rises by one at each edge where the qualified condition is true.
- R5: In mode 1 (edge), the count rises by one at each edge where the qualified condition differs from its value in the previous cycle. The previous value is registered every cycle, whether or not the counter is enabled.
- R6: In mode 2 (threshold), the count rises by one at each edge where the unsigned `evt_lvl` is greater than or equal to the threshold. Mode 3 never counts.
- R7: While the enable bit is 0, the count holds its value.
- R8: An increment while the count is all ones loads the reload value instead, at the same edge, and sets the interrupt request.
- R9: The interrupt request stays set until a control write with bit 4 set. When an overflow and such a clear fall in the same cycle, the request stays set.
- R10: A write to address 1 overrides an increment in the same cycle. The count takes the written value, and no overflow or interrupt results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 count, 2 reload, 3 none) |
| wr_data | input | CNT_W | Write data |
| evt_raw | input | EVT_W | Raw sub-event signals for this cycle |
| evt_lvl | input | LVL_W | Per-cycle event tally used in threshold mode |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | Sticky overflow interrupt request |

## Verification
The bench builds the counter with a 12-bit count, four sub-event bits and a 3-bit tally. With these sizes the control word exactly fills the data word, and the wrap is reached in a few cycles after a near-full load.

These sizes allow several full sweeps:
- all 16 masks against all 16 raw patterns, with and without inversion;
- all 8 thresholds against all 8 tally values.

The bench also steps through a toggling edge sequence. At the wrap it checks the reload and interrupt timing, including a clear that lands on the overflow cycle and a count write that lands on an increment.

// File: rtl/pec_pkg.sv
// Package: shared encodings for the performance event counter.
// Assumes a two-bit register address and a two-bit mode field.
package pec_pkg;
    typedef enum logic [1:0] {
        MODE_LEVEL  = 2'd0,
        MODE_EDGE   = 2'd1,
        MODE_THRESH = 2'd2,
        MODE_OFF    = 2'd3
    } cnt_mode_e;

    localparam logic [1:0] ADDR_CTRL    = 2'd0;
    localparam logic [1:0] ADDR_COUNT   = 2'd1;
    localparam logic [1:0] ADDR_PRELOAD = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MODE_LSB = 1;
    localparam int CTRL_INV_BIT  = 3;
    localparam int CTRL_CLR_BIT  = 4;
    localparam int CTRL_MASK_LSB = 5;
endpackage

// File: rtl/pec_cfg.sv
// Module: pec_cfg
// Holds the control fields and the reload value, and decodes the write port
// into a count-load strobe and an interrupt-clear strobe.
// Assumes CNT_W is wide enough to carry all control fields.
module pec_cfg
    import pec_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int EVT_W = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             en,
    output cnt_mode_e        mode,
    output logic             inv,
    output logic [EVT_W-1:0] mask,
    output logic [LVL_W-1:0] thresh,
    output logic [CNT_W-1:0] preload,
    output logic             cnt_wr,
    output logic             irq_clr
);
    localparam int TH_LSB = CTRL_MASK_LSB + EVT_W;

    logic ctrl_wr;

    // Decode the register strobes from the write port.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        cnt_wr  = wr_en && (wr_addr == ADDR_COUNT);
        irq_clr = ctrl_wr && wr_data[CTRL_CLR_BIT];
    end

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            mode   <= MODE_LEVEL;
            inv    <= 1'b0;
            mask   <= '0;
            thresh <= '0;
        end else if (ctrl_wr) begin
            en     <= wr_data[CTRL_EN_BIT];
            mode   <= cnt_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
            inv    <= wr_data[CTRL_INV_BIT];
            mask   <= wr_data[CTRL_MASK_LSB +: EVT_W];
            thresh <= wr_data[TH_LSB +: LVL_W];
        end
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            preload <= '0;
        else if (wr_en && (wr_addr == ADDR_PRELOAD))
            preload <= wr_data;
    end
endmodule

// File: rtl/pec_cond.sv
// Module: pec_cond
// Qualifies the raw events with the mask, applies inversion and turns the
// selected counting mode into a one-cycle increment request.
// Assumes evt_lvl is an unsigned tally valid in the same cycle as evt_raw.
module pec_cond
    import pec_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  cnt_mode_e        mode,
    input  logic             inv,
    input  logic [EVT_W-1:0] mask,
    input  logic [LVL_W-1:0] thresh,
    input  logic [EVT_W-1:0] evt_raw,
    input  logic [LVL_W-1:0] evt_lvl,
    output logic             inc
);
    logic [EVT_W-1:0] qual_bits;
    logic             cond_now;
    logic             cond_prev;

    // One gate per sub-event bit: raw bit passes only when enabled in the mask.
    for (genvar gi = 0; gi < EVT_W; gi++) begin : g_qual
        assign qual_bits[gi] = evt_raw[gi] & mask[gi];
    end

    // Qualified condition, optionally complemented.
    assign cond_now = (|qual_bits) ^ inv;

    // Previous condition for edge detection, updated every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_prev <= 1'b0;
        else        cond_prev <= cond_now;
    end

    // Mode select into an increment request.
    always_comb begin
        inc = 1'b0;
        if (en) begin
            case (mode)
                MODE_LEVEL:  inc = cond_now;
                MODE_EDGE:   inc = cond_now ^ cond_prev;
                MODE_THRESH: inc = (evt_lvl >= thresh);
                default:     inc = 1'b0;
            endcase
        end
    end

    // R6: threshold mode only counts when the tally reaches the threshold
    assert_thresh_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_THRESH && inc) |-> (evt_lvl >= thresh));
    // R6: mode 3 never requests an increment
    assert_off_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> !inc);
    // R5: no increment in edge mode when the condition repeats last cycle's value
    assert_edge_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EDGE && cond_now == cond_prev) |-> !inc);
    // R7: a disabled counter never requests an increment
    assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !inc);
endmodule

// File: rtl/pec_accum.sv
// Module: pec_accum
// The count register with write priority, wrap-and-reload and the sticky
// interrupt request. Assumes inc is a single-cycle request.
module pec_accum #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] preload,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic wrap;

    // Overflow occurs only for an increment that is not overridden by a write.
    assign wrap = inc && !cnt_wr && (count == CNT_MAX);

    // Count register: write first, then wrap-reload, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_wr) count <= wr_data;
        else if (wrap)   count <= preload;
        else if (inc)    count <= count + 1'b1;
    end

    // Sticky interrupt request; a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (wrap)    irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    // R8: wrap loads the reload value and raises the request
    assert_wrap_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr && count == CNT_MAX) |=> (count == $past(preload) && irq));
    // R4: a plain increment advances the count by exactly one
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
    // R7: with no request and no write the count is held
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !cnt_wr) |=> $stable(count));
    // R10: a count write always wins
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wr_data)));
    // R9: the request stays set until cleared
    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/perf_event_counter.sv
// Module: perf_event_counter
// Top of one performance event counter: configuration, event qualification
// and mode logic, and the wrapping count with its interrupt request.
// Assumes CNT_W >= 5 + EVT_W + LVL_W so the control word fits.
module perf_event_counter
    import pec_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int EVT_W = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [EVT_W-1:0] evt_raw,
    input  logic [LVL_W-1:0] evt_lvl,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic             en;
    cnt_mode_e        mode;
    logic             inv;
    logic [EVT_W-1:0] mask;
    logic [LVL_W-1:0] thresh;
    logic [CNT_W-1:0] preload;
    logic             cnt_wr;
    logic             irq_clr;
    logic             inc;

    pec_cfg #(.CNT_W(CNT_W), .EVT_W(EVT_W), .LVL_W(LVL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en(en), .mode(mode), .inv(inv), .mask(mask),
        .thresh(thresh), .preload(preload), .cnt_wr(cnt_wr), .irq_clr(irq_clr)
    );

    pec_cond #(.EVT_W(EVT_W), .LVL_W(LVL_W)) u_cond (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .inv(inv),
        .mask(mask), .thresh(thresh), .evt_raw(evt_raw), .evt_lvl(evt_lvl),
        .inc(inc)
    );

    pec_accum #(.CNT_W(CNT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .inc(inc), .cnt_wr(cnt_wr),
        .wr_data(wr_data), .preload(preload), .irq_clr(irq_clr),
        .count(count_o), .irq(irq_o)
    );

    // R1: the request is low in the first cycle after reset
    assert_reset_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/sim_perf_event_counter.sv
// Bench: drives the counter at the falling edge, keeps its own model of the
// registers built from the requirements, and compares after each rising edge.
module sim_perf_event_counter;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 12;
    localparam int EVT_W = 4;
    localparam int LVL_W = 3;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [EVT_W-1:0] evt_raw = '0;
    logic [LVL_W-1:0] evt_lvl = '0;
    logic [CNT_W-1:0] count_o;
    logic             irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench-side model state
    logic             m_en = 0, m_inv = 0, m_prev = 0, m_irq = 0;
    logic [1:0]       m_mode = 0;
    logic [EVT_W-1:0] m_mask = 0;
    logic [LVL_W-1:0] m_th = 0;
    logic [CNT_W-1:0] m_pre = 0, m_cnt = 0;

    perf_event_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W), .LVL_W(LVL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_raw(evt_raw), .evt_lvl(evt_lvl),
        .count_o(count_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [CNT_W-1:0] ctrl_word(input logic en, input logic [1:0] md,
            input logic iv, input logic clr, input logic [EVT_W-1:0] mk,
            input logic [LVL_W-1:0] th);
        return {th, mk, clr, iv, md, en};
    endfunction

    task automatic check(input string tag);
        checks++;
        if (count_o !== m_cnt || irq_o !== m_irq) begin
            failures++;
            $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                     tag, count_o, irq_o, m_cnt, m_irq);
        end
    endtask

    // One cycle: drive, advance the model, clock, compare.
    task automatic step(input logic [EVT_W-1:0] raw, input logic [LVL_W-1:0] lvl,
                        input logic we, input logic [1:0] addr,
                        input logic [CNT_W-1:0] data, input string tag);
        logic cond, inc, wrap;
        @(negedge clk);
        evt_raw = raw; evt_lvl = lvl; wr_en = we; wr_addr = addr; wr_data = data;
        cond = ((raw & m_mask) != 0) ^ m_inv;
        inc = 1'b0;
        if (m_en) begin
            if (m_mode == 2'd0)      inc = cond;
            else if (m_mode == 2'd1) inc = (cond != m_prev);
            else if (m_mode == 2'd2) inc = (lvl >= m_th);
        end
        wrap = 1'b0;
        if (we && addr == 2'd1) m_cnt = data;
        else if (inc && m_cnt == MAXV) begin m_cnt = m_pre; wrap = 1'b1; end
        else if (inc) m_cnt = m_cnt + 1'b1;
        if (wrap) m_irq = 1'b1;
        else if (we && addr == 2'd0 && data[4]) m_irq = 1'b0;
        m_prev = cond;
        if (we && addr == 2'd0) begin
            m_en = data[0]; m_mode = data[2:1]; m_inv = data[3];
            m_mask = data[5 +: EVT_W]; m_th = data[5+EVT_W +: LVL_W];
        end
        if (we && addr == 2'd2) m_pre = data;
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic idle_step(input logic [EVT_W-1:0] raw, input string tag);
        step(raw, '0, 1'b0, 2'd0, '0, tag);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 reset state");

        // R2: address 3 writes nothing; counter stays disabled at zero (R7)
        step('1, '1, 1'b1, 2'd3, '1, "R2 address 3 ignored");
        idle_step('1, "R7 disabled after reset");

        // R3 R4: level mode over every mask and raw pattern, both polarities
        for (int iv = 0; iv < 2; iv++) begin
            for (int mk = 0; mk < 16; mk++) begin
                step('0, '0, 1'b1, 2'd0,
                     ctrl_word(1'b1, 2'd0, iv[0], 1'b0, mk[3:0], '0), "R2 ctrl write");
                for (int rw = 0; rw < 16; rw++)
                    idle_step(rw[3:0], iv ? "R3 inverted level count" : "R4 level count");
            end
        end

        // R6: threshold mode, all thresholds against all tallies
        for (int th = 0; th < 8; th++) begin
            step('0, '0, 1'b1, 2'd0,
                 ctrl_word(1'b1, 2'd2, 1'b0, 1'b0, '0, th[2:0]), "R2 ctrl write");
            for (int lv = 0; lv < 8; lv++)
                step('0, lv[2:0], 1'b0, 2'd0, '0, "R6 threshold count");
        end
        step('0, '0, 1'b1, 2'd0, ctrl_word(1'b1, 2'd3, 1'b0, 1'b0, '1, '0), "R6 mode 3");
        for (int k = 0; k < 4; k++) step('1, '1, 1'b0, 2'd0, '0, "R6 mode 3 no count");

        // R5: edge mode with a toggling sequence, then inverted
        for (int iv = 0; iv < 2; iv++) begin
            step('0, '0, 1'b1, 2'd0,
                 ctrl_word(1'b1, 2'd1, iv[0], 1'b0, 4'b0110, '0), "R2 ctrl write");
            for (int k = 0; k < 40; k++)
                idle_step(4'((k * 7) ^ (k >> 1)), "R5 edge count");
        end

        // R7: enable cleared freezes the count
        step('0, '0, 1'b1, 2'd0, ctrl_word(1'b0, 2'd0, 1'b0, 1'b0, '1, '0), "R2 ctrl write");
        for (int k = 0; k < 6; k++) idle_step('1, "R7 frozen while disabled");

        // R8: wrap reloads and raises the request
        step('0, '0, 1'b1, 2'd2, CNT_W'(4096 - 5), "R2 reload write");
        step('0, '0, 1'b1, 2'd1, CNT_W'(4093), "R2 count write");
        step('0, '0, 1'b1, 2'd0, ctrl_word(1'b1, 2'd0, 1'b0, 1'b0, 4'b0001, '0), "R2 ctrl write");
        for (int k = 0; k < 6; k++) idle_step(4'b0001, "R8 wrap and reload");

        // R9: request sticky, then cleared
        for (int k = 0; k < 3; k++) idle_step(4'b0000, "R9 request held");
        step('0, '0, 1'b1, 2'd0, ctrl_word(1'b1, 2'd0, 1'b0, 1'b1, 4'b0001, '0), "R9 clear");
        idle_step('0, "R9 cleared stays low");

        // R9: overflow and clear in the same cycle, set wins
        step('0, '0, 1'b1, 2'd1, MAXV, "R2 count write");
        step(4'b0001, '0, 1'b1, 2'd0, ctrl_word(1'b1, 2'd0, 1'b0, 1'b1, 4'b0001, '0),
             "R9 set wins over clear");
        step('0, '0, 1'b1, 2'd0, ctrl_word(1'b1, 2'd0, 1'b0, 1'b1, 4'b0001, '0), "R9 clear");

        // R10: count write beats an increment, even at all ones
        step(4'b0001, '0, 1'b1, 2'd1, CNT_W'(77), "R10 write over increment");
        step('0, '0, 1'b1, 2'd1, MAXV, "R2 count write");
        step(4'b0001, '0, 1'b1, 2'd1, MAXV, "R10 no wrap on write");
        idle_step(4'b0001, "R8 wrap after write");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule